// File: doc/BRIEF.md
# PCM Playout Engine with In-Band Padding Control

This block plays voice samples out of per-channel circular buffers onto a TDM backplane, one byte per served time slot. An upstream packet disassembler pushes entries into a channel's buffer. A time-slot scheduler names the channel due in each slot, and the engine answers one cycle later with the byte for that slot. Each channel keeps its own control entry: read and write pointers, the input and output companding laws, a padding policy, a constant padding byte, the last valid output byte, and a counter of time without valid data.

Each buffer entry carries a tag bit that marks it as a voice byte or as a padding-policy marker. Voice bytes are translated between mu-law and A-law when the channel's two laws differ. The translation expands the byte to linear and compresses it again. When the buffer is empty, the slot is filled from the padding source the channel currently selects. A marker entry, which the disassembler writes on receiving comfort-noise or silence-descriptor packets, replaces the channel's padding policy. A saturating counter reports, in milliseconds at an 8 kHz frame rate, how long the channel has gone without a valid byte.

Top module: `pcm_playout`

## Requirements
- R1: After reset every channel has mu-law input and output, silence padding and an idle count of 0, and every buffer is empty. A slot served right after reset gives 0xFF with idle count 0, and `outValid` is 0 until the first slot.
- R2: A slot for a channel whose buffer head is a voice entry (tag bit 0) consumes that entry. One cycle later it drives `outValid`=1 and the voice byte. Bytes leave each channel in the order they were written.
- R3: Law encoding is 0 for mu-law and 1 for A-law. With equal laws the byte passes unchanged. With different laws the output is the G.711 re-encoding of the input byte's linear value, using 14-bit linear for mu-law and 13-bit linear for A-law.
- R4: A slot for an empty channel outputs padding chosen by the padding type. Type 0 (and the reserved type 3) gives silence in the output law: 0xFF for mu-law, 0xD5 for A-law. Type 1 repeats the last valid output byte, which is silence in the output law after a configuration write. Type 2 gives the channel's constant byte.
- R5: A slot whose buffer head is a marker (tag bit 1) consumes the marker and takes padding type bits [1:0] of its byte. The slot then outputs padding under that new type instead of a voice byte, and later padding keeps the new type.
- R6: `outIdleMs` shows the channel's idle count after the slot. A voice byte clears it. Every 8th padding slot since the last clear adds one, and the count holds at 255.
- R7: Each channel buffer holds DEPTH entries. A write to a full buffer is dropped and leaves the stored entries unchanged.
- R8: Channels are independent: writes, markers, configuration and slots of one channel do not change any other channel's output.
- R9: `outValid` is 1 exactly in the cycle after a cycle with `slotEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write channel configuration |
| cfgCh | input | CH_W | Channel being configured |
| cfgInLaw | input | 1 | Buffer law, 0 mu-law, 1 A-law |
| cfgOutLaw | input | 1 | Bus law, 0 mu-law, 1 A-law |
| cfgPadType | input | 2 | Initial padding type |
| cfgConst | input | 8 | Constant padding byte |
| wrEn | input | 1 | Push one buffer entry |
| wrCh | input | CH_W | Channel of the pushed entry |
| wrMarker | input | 1 | Entry is a padding-type marker |
| wrData | input | 8 | Voice byte, or new type in bits [1:0] |
| slotEn | input | 1 | A time slot is due |
| slotCh | input | CH_W | Channel owning the slot |
| outValid | output | 1 | Slot byte valid |
| outByte | output | 8 | Byte for the bus |
| outIdleMs | output | 8 | Idle count of the served channel |

## Verification
The translation is tried with random bytes under all four law pairs. Pass-through cases separate a missing bypass from a wrong expansion, and the two cross-law cases separate the mu-law and A-law encoders. Directed runs pad empty channels under every type, including the reserved one, after configuration writes and after real data. This shows whether "repeat" really holds the last translated byte and whether silence follows the output law. Marker entries mixed into the stream show that a marker produces no data byte and that its type persists. A long empty stretch walks the idle counter to saturation, and overfilling a buffer exposes a write that is not dropped.

// File: rtl/pcm_play_pkg.sv
package pcm_play_pkg;

  typedef enum logic [1:0] {
    PAD_SILENCE = 2'd0,
    PAD_REPEAT  = 2'd1,
    PAD_CONST   = 2'd2,
    PAD_RSVD    = 2'd3
  } padKind_t;

  // strobes from control to datapath for one slot
  typedef struct packed {
    logic       fire;
    logic       useData;
    padKind_t   padSel;
    logic       inLaw;
    logic       outLaw;
    logic [7:0] constByte;
    logic [7:0] lastByte;
  } dpCtl_t;

  function automatic logic [7:0] silenceOf(input logic law);
    return law ? 8'hD5 : 8'hFF;
  endfunction

  function automatic logic signed [15:0] expandMu(input logic [7:0] b);
    logic [7:0]  u;
    logic [15:0] t;
    u = ~b;
    t = {8'd0, ({1'b0, u[3:0], 3'b000} + 8'h84)} << u[6:4];
    return u[7] ? signed'(16'h0084 - t) : signed'(t - 16'h0084);
  endfunction

  function automatic logic signed [15:0] expandA(input logic [7:0] b);
    logic [7:0]  a;
    logic [15:0] t;
    a = b ^ 8'h55;
    t = {8'd0, a[3:0], 4'b0000};
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else                t = (t + 16'h0108) << (a[6:4] - 3'd1);
    return a[7] ? signed'(t) : -signed'(t);
  endfunction

  function automatic logic [7:0] compressMu(input logic signed [15:0] x);
    logic signed [15:0] p;
    logic [15:0] m;
    logic [7:0]  mask;
    logic [3:0]  seg;
    p = x >>> 2;
    if (p < 0) begin p = -p; mask = 8'h7F; end
    else       mask = 8'hFF;
    if (p > 16'sd8159) p = 16'sd8159;
    m = unsigned'(p) + 16'd33;
    seg = 4'd8;
    for (int i = 7; i >= 0; i--) if (m < (16'd64 << i)) seg = 4'(i);
    if (seg[3]) return 8'h7F ^ mask;
    return {1'b0, seg[2:0], 4'(m >> (seg + 4'd1))} ^ mask;
  endfunction

  function automatic logic [7:0] compressA(input logic signed [15:0] x);
    logic signed [15:0] p;
    logic [15:0] m;
    logic [7:0]  mask;
    logic [3:0]  seg;
    p = x >>> 3;
    if (p >= 0) mask = 8'hD5;
    else begin mask = 8'h55; p = -p - 16'sd1; end
    m = unsigned'(p);
    seg = 4'd8;
    for (int i = 7; i >= 0; i--) if (m < (16'd32 << i)) seg = 4'(i);
    if (seg[3]) return 8'h7F ^ mask;
    if (seg < 4'd2) return {1'b0, seg[2:0], 4'(m >> 1)} ^ mask;
    return {1'b0, seg[2:0], 4'(m >> seg)} ^ mask;
  endfunction

  function automatic logic [7:0] translate(input logic [7:0] b, input logic inL,
                                           input logic outL);
    logic signed [15:0] lin;
    if (inL == outL) return b;
    lin = inL ? expandA(b) : expandMu(b);
    return outL ? compressA(lin) : compressMu(lin);
  endfunction

endpackage

// File: rtl/pcm_play_ctrl.sv
module pcm_play_ctrl
  import pcm_play_pkg::*;
#(
  parameter int CH_W    = 3,
  parameter int DEPTH_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [CH_W-1:0]          cfgCh,
  input  logic                     cfgInLaw,
  input  logic                     cfgOutLaw,
  input  logic [1:0]               cfgPadType,
  input  logic [7:0]               cfgConst,
  input  logic                     wrEn,
  input  logic [CH_W-1:0]          wrCh,
  input  logic                     slotEn,
  input  logic [CH_W-1:0]          slotCh,
  input  logic                     headTag,
  input  logic [1:0]               headPad,
  input  logic [7:0]               xlatByte,
  output logic                     wrAccept,
  output logic [CH_W+DEPTH_W-1:0]  wrAddr,
  output logic [CH_W+DEPTH_W-1:0]  rdAddr,
  output dpCtl_t                   ctl,
  output logic [7:0]               idleMs
);
  localparam int NUM_CH = 1 << CH_W;
  localparam int DEPTH  = 1 << DEPTH_W;
  localparam int PTR_W  = DEPTH_W + 1;

  logic [PTR_W-1:0] rdPtr   [NUM_CH];
  logic [PTR_W-1:0] wrPtr   [NUM_CH];
  logic             inLaw   [NUM_CH];
  logic             outLaw  [NUM_CH];
  padKind_t         padType [NUM_CH];
  logic [7:0]       constB  [NUM_CH];
  logic [7:0]       lastB   [NUM_CH];
  logic [7:0]       idle    [NUM_CH];
  logic [2:0]       subCnt  [NUM_CH];

  logic             empty, isMarker, isData;
  logic [PTR_W-1:0] occWr;
  logic [7:0]       nextIdle;

  always_comb begin
    occWr    = wrPtr[wrCh] - rdPtr[wrCh];
    wrAccept = wrEn && (occWr != PTR_W'(DEPTH));
    wrAddr   = {wrCh, wrPtr[wrCh][DEPTH_W-1:0]};
    rdAddr   = {slotCh, rdPtr[slotCh][DEPTH_W-1:0]};
    empty    = (rdPtr[slotCh] == wrPtr[slotCh]);
    isMarker = !empty && headTag;
    isData   = !empty && !headTag;

    ctl.fire      = slotEn;
    ctl.useData   = isData;
    ctl.padSel    = isMarker ? padKind_t'(headPad) : padType[slotCh];
    ctl.inLaw     = inLaw[slotCh];
    ctl.outLaw    = outLaw[slotCh];
    ctl.constByte = constB[slotCh];
    ctl.lastByte  = lastB[slotCh];

    nextIdle = idle[slotCh];
    if (subCnt[slotCh] == 3'd7 && idle[slotCh] != 8'hFF) nextIdle = idle[slotCh] + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        rdPtr[c]   <= '0;
        wrPtr[c]   <= '0;
        inLaw[c]   <= 1'b0;
        outLaw[c]  <= 1'b0;
        padType[c] <= PAD_SILENCE;
        constB[c]  <= 8'hFF;
        lastB[c]   <= 8'hFF;
        idle[c]    <= '0;
        subCnt[c]  <= '0;
      end
      idleMs <= '0;
    end else begin
      if (wrAccept) wrPtr[wrCh] <= wrPtr[wrCh] + 1'b1;
      if (slotEn) begin
        if (!empty) rdPtr[slotCh] <= rdPtr[slotCh] + 1'b1;
        if (isMarker) padType[slotCh] <= padKind_t'(headPad);
        if (isData) begin
          lastB[slotCh]  <= xlatByte;
          idle[slotCh]   <= '0;
          subCnt[slotCh] <= '0;
          idleMs         <= '0;
        end else begin
          subCnt[slotCh] <= subCnt[slotCh] + 3'd1;
          idle[slotCh]   <= nextIdle;
          idleMs         <= nextIdle;
        end
      end
      if (cfgWe) begin
        inLaw[cfgCh]   <= cfgInLaw;
        outLaw[cfgCh]  <= cfgOutLaw;
        padType[cfgCh] <= padKind_t'(cfgPadType);
        constB[cfgCh]  <= cfgConst;
        lastB[cfgCh]   <= silenceOf(cfgOutLaw);
      end
    end
  end

  // R7: a buffer never holds more than DEPTH entries
  p_buffer_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr[wrCh] - rdPtr[wrCh]) <= PTR_W'(DEPTH));

  // R5: a consumed marker becomes the channel's padding type
  p_marker_sets_type_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slotEn && isMarker && !(cfgWe && cfgCh == slotCh))
      |=> padType[$past(slotCh)] == padKind_t'($past(headPad)));

  // R6: a saturated idle count stays at 255 across padding slots
  p_idle_saturates_r6: assert property (@(posedge clk) disable iff (!rstN)
    (slotEn && !isData && idle[slotCh] == 8'hFF) |=> idleMs == 8'hFF);

endmodule

// File: rtl/pcm_play_dp.sv
module pcm_play_dp
  import pcm_play_pkg::*;
#(
  parameter int CH_W    = 3,
  parameter int DEPTH_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrAccept,
  input  logic [CH_W+DEPTH_W-1:0]  wrAddr,
  input  logic [8:0]               wrEntry,
  input  logic [CH_W+DEPTH_W-1:0]  rdAddr,
  input  dpCtl_t                   ctl,
  output logic                     headTag,
  output logic [1:0]               headPad,
  output logic [7:0]               xlatByte,
  output logic                     outValid,
  output logic [7:0]               outByte
);
  localparam int ENTRIES = 1 << (CH_W + DEPTH_W);

  logic [8:0] bufMem [ENTRIES];
  logic [8:0] headEntry;
  logic [7:0] padByte;

  always_ff @(posedge clk) begin
    if (wrAccept) bufMem[wrAddr] <= wrEntry;
  end

  always_comb begin
    headEntry = bufMem[rdAddr];
    headTag   = headEntry[8];
    headPad   = headEntry[1:0];
    xlatByte  = translate(headEntry[7:0], ctl.inLaw, ctl.outLaw);
    case (ctl.padSel)
      PAD_REPEAT: padByte = ctl.lastByte;
      PAD_CONST:  padByte = ctl.constByte;
      default:    padByte = silenceOf(ctl.outLaw);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
    end else begin
      outValid <= ctl.fire;
      if (ctl.fire) outByte <= ctl.useData ? xlatByte : padByte;
    end
  end

  // R4: silence padding follows the output law
  p_silence_law_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && !ctl.useData && ctl.padSel == PAD_SILENCE)
      |=> outByte == ($past(ctl.outLaw) ? 8'hD5 : 8'hFF));

  // R3: equal laws pass the stored byte through untouched
  p_pass_through_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.useData && ctl.inLaw == ctl.outLaw)
      |=> outByte == $past(headEntry[7:0]));

endmodule

// File: rtl/pcm_playout.sv
module pcm_playout
  import pcm_play_pkg::*;
#(
  parameter int CH_W    = 3,
  parameter int DEPTH_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [CH_W-1:0] cfgCh,
  input  logic            cfgInLaw,
  input  logic            cfgOutLaw,
  input  logic [1:0]      cfgPadType,
  input  logic [7:0]      cfgConst,
  input  logic            wrEn,
  input  logic [CH_W-1:0] wrCh,
  input  logic            wrMarker,
  input  logic [7:0]      wrData,
  input  logic            slotEn,
  input  logic [CH_W-1:0] slotCh,
  output logic            outValid,
  output logic [7:0]      outByte,
  output logic [7:0]      outIdleMs
);
  localparam int AW = CH_W + DEPTH_W;

  dpCtl_t        ctl;
  logic          wrAccept, headTag;
  logic [1:0]    headPad;
  logic [7:0]    xlatByte;
  logic [AW-1:0] wrAddr, rdAddr;

  pcm_play_ctrl #(.CH_W(CH_W), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgInLaw(cfgInLaw), .cfgOutLaw(cfgOutLaw),
    .cfgPadType(cfgPadType), .cfgConst(cfgConst),
    .wrEn(wrEn), .wrCh(wrCh), .slotEn(slotEn), .slotCh(slotCh),
    .headTag(headTag), .headPad(headPad), .xlatByte(xlatByte),
    .wrAccept(wrAccept), .wrAddr(wrAddr), .rdAddr(rdAddr), .ctl(ctl),
    .idleMs(outIdleMs)
  );

  pcm_play_dp #(.CH_W(CH_W), .DEPTH_W(DEPTH_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrAccept(wrAccept), .wrAddr(wrAddr), .wrEntry({wrMarker, wrData}),
    .rdAddr(rdAddr), .ctl(ctl),
    .headTag(headTag), .headPad(headPad), .xlatByte(xlatByte),
    .outValid(outValid), .outByte(outByte)
  );

  // R9: output strobe only follows a served slot
  p_valid_after_slot_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(slotEn));

endmodule

// File: tb/pcm_playout_tb.sv
module pcm_playout_tb;
  localparam int CH_W = 3, DEPTH_W = 3;
  localparam int NCH = 1 << CH_W, DEPTH = 1 << DEPTH_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, cfgInLaw = 0, cfgOutLaw = 0, wrEn = 0, wrMarker = 0, slotEn = 0;
  logic [CH_W-1:0] cfgCh = '0, wrCh = '0, slotCh = '0;
  logic [1:0] cfgPadType = '0;
  logic [7:0] cfgConst = '0, wrData = '0;
  logic outValid;
  logic [7:0] outByte, outIdleMs;

  always #4 clk = ~clk;

  pcm_playout #(.CH_W(CH_W), .DEPTH_W(DEPTH_W)) u_dut (.*);

  int checks = 0, errors = 0;

  // reference model state
  int mq [NCH][DEPTH];
  int mHead [NCH], mCnt [NCH], mIn [NCH], mOut [NCH], mPad [NCH];
  int mConst [NCH], mLast [NCH], mIdle [NCH], mSub [NCH];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int silence(int law);
    return law ? 'hD5 : 'hFF;
  endfunction

  function automatic int muToLin(int b);
    int u = (~b) & 255;
    int e = (u >> 4) & 7, m = u & 15;
    int mag = (((2 * m + 33) << e) - 33) * 4;
    return (u & 128) ? -mag : mag;
  endfunction

  function automatic int aToLin(int b);
    int a = b ^ 'h55;
    int e = (a >> 4) & 7, m = a & 15;
    int mag = (e == 0) ? (2 * m + 1) * 8 : ((2 * m + 33) << (e - 1)) * 8;
    return (a & 128) ? mag : -mag;
  endfunction

  function automatic int linToMu(int x);
    int v = x >>> 2, mask = 'hFF, e = 0;
    if (v < 0) begin v = -v; mask = 'h7F; end
    if (v > 8159) v = 8159;
    v += 33;
    while (e < 8 && v >= (64 << e)) e++;
    if (e == 8) return 'h7F ^ mask;
    return ((e << 4) | ((v >> (e + 1)) & 15)) ^ mask;
  endfunction

  function automatic int linToA(int x);
    int v = x >>> 3, mask = 'hD5, e = 0;
    if (v < 0) begin mask = 'h55; v = -v - 1; end
    while (e < 8 && v >= (32 << e)) e++;
    if (e == 8) return 'h7F ^ mask;
    return ((e << 4) | (((e == 0) ? v >> 1 : v >> e) & 15)) ^ mask;
  endfunction

  function automatic int xlat(int b, int inL, int outL);
    int lin;
    if (inL == outL) return b;
    lin = inL ? aToLin(b) : muToLin(b);
    return outL ? linToA(lin) : linToMu(lin);
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      mHead[c] = 0; mCnt[c] = 0; mIn[c] = 0; mOut[c] = 0; mPad[c] = 0;
      mConst[c] = 'hFF; mLast[c] = 'hFF; mIdle[c] = 0; mSub[c] = 0;
    end
  endtask

  task automatic cfg(int ch, int inL, int outL, int pad, int cst);
    cfgWe = 1; cfgCh = CH_W'(ch); cfgInLaw = inL[0]; cfgOutLaw = outL[0];
    cfgPadType = pad[1:0]; cfgConst = cst[7:0];
    @(negedge clk);
    cfgWe = 0;
    mIn[ch] = inL; mOut[ch] = outL; mPad[ch] = pad; mConst[ch] = cst;
    mLast[ch] = silence(outL);
  endtask

  task automatic push(int ch, int mk, int d);
    wrEn = 1; wrCh = CH_W'(ch); wrMarker = mk[0]; wrData = d[7:0];
    @(negedge clk);
    wrEn = 0;
    check("R9 no strobe without slot", outValid, 0);
    if (mCnt[ch] < DEPTH) begin
      mq[ch][(mHead[ch] + mCnt[ch]) % DEPTH] = (mk << 8) | d;
      mCnt[ch]++;
    end
  endtask

  task automatic slot(int ch, string req);
    int expB, e;
    bit data = 0;
    if (mCnt[ch] > 0) begin
      e = mq[ch][mHead[ch]];
      mHead[ch] = (mHead[ch] + 1) % DEPTH; mCnt[ch]--;
      if (e & 256) mPad[ch] = e & 3;
      else data = 1;
    end
    if (data) begin
      expB = xlat(e & 255, mIn[ch], mOut[ch]);
      mLast[ch] = expB; mIdle[ch] = 0; mSub[ch] = 0;
    end else begin
      case (mPad[ch])
        1: expB = mLast[ch];
        2: expB = mConst[ch];
        default: expB = silence(mOut[ch]);
      endcase
      if (mSub[ch] == 7 && mIdle[ch] < 255) mIdle[ch]++;
      mSub[ch] = (mSub[ch] + 1) % 8;
    end
    slotEn = 1; slotCh = CH_W'(ch);
    @(negedge clk);
    slotEn = 0;
    check({req, " R9 strobe"}, outValid, 1);
    check({req, " byte"}, outByte, expB);
    check({req, " R6 idle"}, outIdleMs, mIdle[ch]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    check("R1 reset valid", outValid, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 idle valid", outValid, 0);
    slot(0, "R1 empty after reset");

    // R2 FIFO order and R3 pass-through
    push(1, 0, 'h12); push(1, 0, 'h9A); push(1, 0, 'h00);
    slot(2, "R8 other channel empty");
    slot(1, "R2 first"); slot(1, "R2 second"); slot(1, "R3 pass");

    // R3 cross laws
    cfg(2, 0, 1, 0, 0);
    push(2, 0, 'hFF); push(2, 0, 'h00); push(2, 0, 'h80); push(2, 0, 'h7F);
    for (int i = 0; i < 4; i++) slot(2, "R3 mu to A");
    slot(2, "R4 silence in A-law");
    cfg(3, 1, 0, 1, 0);
    slot(3, "R4 repeat after cfg");
    push(3, 0, 'hD5); push(3, 0, 'h2A);
    slot(3, "R3 A to mu"); slot(3, "R3 A to mu");
    slot(3, "R4 repeat last"); slot(3, "R4 repeat again");

    // R5 markers
    cfg(4, 0, 0, 0, 'h5C);
    push(4, 0, 'h33); push(4, 1, 2); push(4, 0, 'h44);
    slot(4, "R2 before marker"); slot(4, "R5 marker pads");
    slot(4, "R2 after marker"); slot(4, "R5 const kept");
    push(4, 1, 3); slot(4, "R5 reserved type"); slot(4, "R4 reserved silence");

    // R7 overflow
    for (int i = 0; i < DEPTH + 2; i++) push(5, 0, 16 + i);
    for (int i = 0; i < DEPTH + 1; i++) slot(5, "R7 full drop");

    // R6 idle saturation
    for (int i = 0; i < 8 * 260; i++) slot(6, "R6 saturate");
    push(6, 0, 'h21); slot(6, "R6 clear on data");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom % 10;
      int ch = $urandom % NCH;
      if (op == 0) cfg(ch, $urandom % 2, $urandom % 2, $urandom % 4, $urandom % 256);
      else if (op < 5) push(ch, ($urandom % 6) == 0, $urandom % 256);
      else slot(ch, "R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule